// File: doc/BRIEF.md
# Programmable Frame Sync Generator

This block drives the frame sync line of a serial port. Time is measured in bit clocks: the block runs on a fast system clock, and a one-cycle enable marks each bit clock. Two settings shape the pulse. A 12-bit period setting gives a frame of period+1 bit clocks. An 8-bit width setting gives a high pulse of width+1 bit clocks at the start of each frame. Both settings are captured when a frame begins, so a change made in the middle of a frame takes effect at the next frame.

Two control bits gate generation: a run bit and a generator-mode bit. The pulse is produced only while both are 1. In external-sync mode the period setting is ignored. A new frame then starts on each rising edge of an external frame input, seen on a bit-clock tick, and only the width setting sets how long the pulse lasts. A loopback select feeds the transmit frame sync and transmit data to the receive-side outputs in place of the receive pins.

Top module: `frame_sync_gen`

## Requirements
- R1: While reset is asserted and after its release, `fs_out` is 0 until generation starts.
- R2: In any clock cycle where `gen_run` and `gen_mode` are not both 1, `fs_out` is 0 after the next clock edge, and the next frame restarts from the beginning.
- R3: In normal mode, the first bit-clock tick after generation is enabled starts a frame, and `fs_out` is 1 after that edge.
- R4: `fs_out` stays 1 for exactly `wid_set`+1 bit-clock ticks counted from the tick that starts the frame, and is then 0 for the rest of the frame.
- R5: In normal mode, a new frame starts every `per_set`+1 bit-clock ticks.
- R6: On clock cycles where `bclk_en` is 0, `fs_out` does not change, apart from the forced low of R2.
- R7: When `wid_set` is greater than or equal to `per_set`, `fs_out` stays 1 through every frame, with no low gap.
- R8: When `per_set` and `wid_set` are both 0, `fs_out` stays 1 on every cycle once generation has started.
- R9: With `ext_mode`=1, a frame starts on a tick where `ext_frame_in` is 1 and was 0 at the previous tick. `per_set` has no effect. After the pulse ends, `fs_out` stays 0 until the next rising edge.
- R10: With `loop_sel`=1, `rx_fs` equals `tx_fs` and `rx_data` equals `tx_data`. With `loop_sel`=0 they follow `rx_fs_pin` and `rx_data_pin`. Both paths are combinational.
- R11: `per_set` and `wid_set` are captured at the start of each frame. A change made during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk_en | input | 1 | One-cycle bit-clock tick |
| per_set | input | 12 | Frame period minus one, in bit clocks |
| wid_set | input | 8 | Pulse width minus one, in bit clocks |
| gen_run | input | 1 | Frame generator released from reset when 1 |
| gen_mode | input | 1 | Generator drives frame sync when 1 |
| ext_mode | input | 1 | Frames start on edges of `ext_frame_in` |
| ext_frame_in | input | 1 | External frame input |
| loop_sel | input | 1 | Loopback select |
| tx_fs | input | 1 | Transmit frame sync |
| tx_data | input | 1 | Transmit data |
| rx_fs_pin | input | 1 | Receive frame sync from the pin |
| rx_data_pin | input | 1 | Receive data from the pin |
| fs_out | output | 1 | Generated frame sync |
| rx_fs | output | 1 | Receive frame sync after the loopback mux |
| rx_data | output | 1 | Receive data after the loopback mux |

## Verification
The hardest cases to reach are the frame boundary where the pulse end and the period end fall on the same tick or in reversed order, and a settings change that lands inside a running frame. In both, `fs_out` must follow the captured values, not the live ones. The stimulus covers these with width/period pairs that are equal, reversed or both zero. It rewrites the settings at random points during long runs, and it thins the bit-clock ticks with regular and random gaps. The external-sync runs also toggle the frame input on ticks that fall inside an active pulse, which forces a restart in the middle of a pulse.

// File: rtl/frame_sync_gen.sv
module frame_sync_gen #(
  parameter int PER_W = 12,
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_en,
  input  logic [PER_W-1:0] per_set,
  input  logic [WID_W-1:0] wid_set,
  input  logic             gen_run,
  input  logic             gen_mode,
  input  logic             ext_mode,
  input  logic             ext_frame_in,
  input  logic             loop_sel,
  input  logic             tx_fs,
  input  logic             tx_data,
  input  logic             rx_fs_pin,
  input  logic             rx_data_pin,
  output logic             fs_out,
  output logic             rx_fs,
  output logic             rx_data
);

  logic [PER_W-1:0] per_cnt;
  logic [WID_W-1:0] wid_cnt;
  logic             live;
  logic             ext_prev;

  logic run_ok, ext_rise, per_done, wid_done, start;

  assign run_ok   = gen_run & gen_mode;
  assign ext_rise = ext_frame_in & ~ext_prev;
  assign per_done = (per_cnt == '0);
  assign wid_done = (wid_cnt == '0);
  assign start    = ext_mode ? ext_rise : (~live | per_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt <= '0;
      wid_cnt <= '0;
      live    <= 1'b0;
      fs_out  <= 1'b0;
    end else if (!run_ok) begin
      live   <= 1'b0;
      fs_out <= 1'b0;
    end else if (bclk_en) begin
      if (start) begin
        per_cnt <= per_set;
        wid_cnt <= wid_set;
        live    <= 1'b1;
        fs_out  <= 1'b1;
      end else begin
        if (!ext_mode) per_cnt <= per_cnt - 1'b1;
        if (fs_out) begin
          if (wid_done) fs_out  <= 1'b0;
          else          wid_cnt <= wid_cnt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ext_prev <= 1'b0;
    else if (bclk_en) ext_prev <= ext_frame_in;
  end

  assign rx_fs   = loop_sel ? tx_fs   : rx_fs_pin;
  assign rx_data = loop_sel ? tx_data : rx_data_pin;

endmodule

// File: rtl/frame_sync_gen_chk.sv
module frame_sync_gen_chk #(
  parameter int PER_W = 12,
  parameter int WID_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bclk_en,
  input logic             gen_run,
  input logic             gen_mode,
  input logic             ext_mode,
  input logic             ext_frame_in,
  input logic             loop_sel,
  input logic             tx_fs,
  input logic             tx_data,
  input logic             rx_fs_pin,
  input logic             rx_data_pin,
  input logic             fs_out,
  input logic             rx_fs,
  input logic             rx_data,
  input logic             live,
  input logic             ext_prev,
  input logic [PER_W-1:0] per_cnt,
  input logic [WID_W-1:0] wid_cnt
);

  logic on;
  assign on = gen_run & gen_mode;

  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> !fs_out);

  a_r6_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (on && !bclk_en) |=> $stable(fs_out));

  a_r3_first_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (on && bclk_en && !ext_mode && !live) |=> fs_out);

  a_r5_period_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (on && bclk_en && !ext_mode && live && per_cnt == '0) |=> fs_out);

  a_r4_width_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (on && bclk_en && fs_out && wid_cnt != '0) |=> fs_out);

  a_r9_ext_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (on && bclk_en && ext_mode && ext_frame_in && !ext_prev) |=> fs_out);

  a_r10_loop_path: assert property (@(posedge clk) disable iff (!rst_n)
    loop_sel |-> (rx_fs == tx_fs && rx_data == tx_data));

  a_r10_pin_path: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_sel |-> (rx_fs == rx_fs_pin && rx_data == rx_data_pin));

endmodule

bind frame_sync_gen frame_sync_gen_chk #(.PER_W(PER_W), .WID_W(WID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .gen_run(gen_run),
  .gen_mode(gen_mode), .ext_mode(ext_mode), .ext_frame_in(ext_frame_in),
  .loop_sel(loop_sel), .tx_fs(tx_fs), .tx_data(tx_data),
  .rx_fs_pin(rx_fs_pin), .rx_data_pin(rx_data_pin), .fs_out(fs_out),
  .rx_fs(rx_fs), .rx_data(rx_data), .live(live), .ext_prev(ext_prev),
  .per_cnt(per_cnt), .wid_cnt(wid_cnt)
);

// File: tb/frame_sync_gen_bench.sv
module frame_sync_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk_en = 1'b0;
  logic [11:0] per_set = '0;
  logic [7:0]  wid_set = '0;
  logic        gen_run = 1'b0, gen_mode = 1'b0, ext_mode = 1'b0, ext_frame_in = 1'b0;
  logic        loop_sel = 1'b0, tx_fs = 1'b0, tx_data = 1'b0, rx_fs_pin = 1'b0, rx_data_pin = 1'b0;
  logic        fs_out, rx_fs, rx_data;

  always #2 clk = ~clk;

  frame_sync_gen u_frame_sync_gen (
    .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .per_set(per_set), .wid_set(wid_set),
    .gen_run(gen_run), .gen_mode(gen_mode), .ext_mode(ext_mode), .ext_frame_in(ext_frame_in),
    .loop_sel(loop_sel), .tx_fs(tx_fs), .tx_data(tx_data), .rx_fs_pin(rx_fs_pin),
    .rx_data_pin(rx_data_pin), .fs_out(fs_out), .rx_fs(rx_fs), .rx_data(rx_data)
  );

  int    n_cmp = 0, n_bad = 0, cycles = 0;
  string cur_req = "R1";
  bit    comparing = 1'b0;
  bit    done = 1'b0;

  // behavioural reference: position inside the frame plus captured settings
  bit m_fs, m_live, m_prev;
  int pos, cap_w, cap_p;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fs = 0; m_live = 0; m_prev = 0; pos = 0; cap_w = 0; cap_p = 0;
    end else begin
      if (!(gen_run && gen_mode)) begin
        m_live = 0; m_fs = 0;
      end else if (bclk_en) begin
        if (ext_mode) begin
          if (ext_frame_in && !m_prev) begin
            pos = 0; cap_w = int'(wid_set); m_live = 1;
          end else if (m_live && pos <= cap_w) pos++;
          m_fs = m_live && (pos <= cap_w);
        end else begin
          if (!m_live || pos >= cap_p) begin
            pos = 0; cap_w = int'(wid_set); cap_p = int'(per_set); m_live = 1;
          end else pos++;
          m_fs = (pos <= cap_w);
        end
      end
      if (bclk_en) m_prev = ext_frame_in;
    end
  end

  task automatic check1(string req, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    cycles++;
    if (comparing) begin
      check1(cur_req, "fs_out", fs_out, m_fs);
      check1("R10", "rx_fs", rx_fs, loop_sel ? tx_fs : rx_fs_pin);
      check1("R10", "rx_data", rx_data, loop_sel ? tx_data : rx_data_pin);
    end
  end

  // en_kind: 0 every cycle, 1 every third cycle, 2 random
  task automatic run(int n, int en_kind, bit ext_pulses, bit churn);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (en_kind)
        0: bclk_en = 1'b1;
        1: bclk_en = (i % 3 == 0);
        default: bclk_en = $urandom_range(0, 1) == 1;
      endcase
      if (ext_pulses && $urandom_range(0, 9) == 0) ext_frame_in = ~ext_frame_in;
      if (churn && $urandom_range(0, 40) == 0) begin
        per_set = 12'($urandom_range(0, 20));
        wid_set = 8'($urandom_range(0, 20));
      end
      loop_sel    = $urandom_range(0, 1) == 1;
      tx_fs       = $urandom_range(0, 1) == 1;
      tx_data     = $urandom_range(0, 1) == 1;
      rx_fs_pin   = $urandom_range(0, 1) == 1;
      rx_data_pin = $urandom_range(0, 1) == 1;
    end
  endtask

  task automatic setup(string req, int p, int w, bit ext);
    @(negedge clk);
    gen_run = 1'b0;
    @(negedge clk);
    cur_req = req;
    per_set = 12'(p); wid_set = 8'(w); ext_mode = ext;
    gen_run = 1'b1; gen_mode = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check1("R1", "fs_out in reset", fs_out, 1'b0);
    rst_n = 1'b1;
    comparing = 1'b1;
    run(5, 0, 0, 0);
    check1("R1", "fs_out after reset", fs_out, 1'b0);

    setup("R4", 15, 1, 0);  run(200, 0, 0, 0);
    cur_req = "R5";          run(200, 1, 0, 0);
    setup("R3", 5, 0, 0);    run(60, 2, 0, 0);
    setup("R6", 9, 4, 0);    run(300, 2, 0, 0);
    setup("R7", 3, 7, 0);    run(100, 0, 0, 0);
    setup("R7", 6, 6, 0);    run(100, 1, 0, 0);
    setup("R8", 0, 0, 0);    run(80, 2, 0, 0);
    setup("R5", 4095, 255, 0); run(9000, 0, 0, 0);
    setup("R11", 10, 3, 0);  run(3000, 2, 0, 1);
    cur_req = "R2";
    gen_mode = 1'b0;         run(30, 0, 0, 0);
    gen_mode = 1'b1;         run(40, 0, 0, 0);
    gen_run = 1'b0;          run(30, 1, 0, 0);
    gen_run = 1'b1;          run(40, 1, 0, 0);
    setup("R9", 3, 5, 1);    run(2000, 2, 1, 0);
    setup("R9", 4095, 0, 1); run(1000, 0, 1, 1);
    setup("R9", 0, 12, 1);   run(1500, 1, 1, 1);
    cur_req = "R2";
    gen_mode = 1'b0;         run(50, 0, 1, 0);
    setup("R11", 2, 1, 0);   run(2000, 0, 0, 1);
    setup("R10", 7, 2, 0);   run(500, 2, 0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog run did not end actual=%0d expected<150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule